// File: doc/BRIEF.md
# Multi-Cycle 32-bit Interrupt-Capable Processor Core

This block is a small, non-pipelined 32-bit processor. It fetches one instruction word at a time over a single synchronous memory port, decodes it and executes it over several clock cycles. The same port carries instruction fetches, loads, stores and stack traffic. The core has eight general registers, an instruction pointer (IP) and a stack pointer (SP). The stack grows toward higher addresses.

A peripheral strobe carries a line number to the outside world. A vector of level-sensitive request lines can interrupt the program at instruction boundaries while interrupts are enabled. A software instruction raises a request on line 0, which loops back into the core. Opcode 0x00 stops the core for good, so a program that runs into zero-filled memory halts.

Every instruction is one 32-bit word. The opcode sits in bits 7:0. The register fields sit in bits 10:8 (field A), 18:16 (field B) and 26:24 (field C). Instructions that carry a constant read it from the word that follows.

Top module: `cpu_core`

## Requirements
- R1: Opcode 0x00 sets `halted` and keeps it set until reset, with no further memory access. Coming out of reset with zero memory, `halted` rises on the fourth rising edge after reset is released.
- R2: Fields follow the layout above. Load-constant (0x03, destination B) writes the following word to the register and then advances IP by 8. Every other instruction that does not jump advances IP by 4.
- R3: Two-source ALU operations write `A op B` into register C. The opcodes are 0x21 add, 0x22 subtract, 0x23 multiply (low 32 bits), 0x24 unsigned divide, 0x25 remainder, 0x26 logical right shift, 0x27 left shift, 0x28 OR, 0x29 XOR and 0x2A AND. Divide by zero yields all ones, and remainder by zero yields the dividend.
- R4: Single-source moves write their result into register B: 0x20 writes the bitwise inverse of A, and 0x13 copies A. Opcode 0x12 copies SP into register A.
- R5: Opcode 0x04 stores register A at the address in register B. Opcode 0x05 loads the word at the address in register A into register B.
- R6: Opcode 0x02 jumps to the address in register A. Opcode 0x07 jumps to register B only when register A, read as a signed number, is greater than zero.
- R7: Opcode 0x0B loads SP from register A. Push (0x0C) stores register A at SP and then adds 4 to SP. Pop (0x0D) subtracts 4 from SP and then loads the word at the new SP into register A.
- R8: Call (0x0F) pushes IP+4 and jumps to register A. Return (0x10) pops a word into IP.
- R9: Load-relative (0x0A) writes the address of the instruction plus the signed constant in the following word into register B. It then advances IP by 8.
- R10: Opcode 0x06 raises `prf_stb` for exactly one cycle, with `prf_line` equal to register A.
- R11: Opcode 0x08 sets the interrupt-enable flag and 0x09 clears it. Reset clears it. While it is clear, requests are ignored.
- R12: At an instruction boundary, with the flag set and a request pending, the core pushes the IP of the next instruction, clears the flag and jumps to 0x100 + 4 × line. The lowest pending line wins. Opcode 0x0E makes line 0 pending until that entry is taken.
- R13: Interrupt return (0x11) pops eight words into registers 7 down to 0, then pops IP, then sets the interrupt-enable flag.
- R14: Read data is taken on the cycle after the one in which `mem_rd` is high. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NIRQ | Level-sensitive interrupt requests, bit index = line |
| mem_rd | output | 1 | Memory read request (registered) |
| mem_wr | output | 1 | Memory write request (registered) |
| mem_addr | output | W | Byte address of the access |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid the cycle after `mem_rd` |
| prf_stb | output | 1 | One-cycle peripheral strobe |
| prf_line | output | W | Line number that goes with the strobe |
| halted | output | 1 | High once a halt has executed |

## Verification
The assertions assume that the memory behaves as a synchronous RAM that returns the addressed word exactly one cycle after a read. They also assume that an interrupt request is held as a steady level rather than pulsed. The bench's memory model registers its read data on every edge, and requests are driven only from the bench's own tasks, away from the clock edge, and held until the program halts. Programs keep SP and every data address inside the modelled 4 KiB, so no access wraps.

// File: rtl/cpu_core_pkg.sv
package cpu_core_pkg;

  typedef enum logic [7:0] {
    OP_HALT = 8'h00, OP_NOP  = 8'h01, OP_JMP  = 8'h02, OP_LDC  = 8'h03,
    OP_STM  = 8'h04, OP_LDM  = 8'h05, OP_OUT  = 8'h06, OP_JGT  = 8'h07,
    OP_IEN  = 8'h08, OP_IDIS = 8'h09, OP_LDR  = 8'h0A, OP_LSP  = 8'h0B,
    OP_PSH  = 8'h0C, OP_POP  = 8'h0D, OP_SWI  = 8'h0E, OP_CALL = 8'h0F,
    OP_RET  = 8'h10, OP_IRET = 8'h11, OP_SSP  = 8'h12, OP_MOV  = 8'h13,
    OP_INV  = 8'h20, OP_ADD  = 8'h21, OP_SUB  = 8'h22, OP_MUL  = 8'h23,
    OP_DIV  = 8'h24, OP_MOD  = 8'h25, OP_SHR  = 8'h26, OP_SHL  = 8'h27,
    OP_OR   = 8'h28, OP_XOR  = 8'h29, OP_AND  = 8'h2A
  } opcode_e;

  typedef enum logic [2:0] {
    ST_BOUND, ST_FWAIT, ST_DECODE, ST_EXEC,
    ST_POPREQ, ST_RWAIT, ST_RDATA, ST_HALT
  } state_e;

  localparam int FIELD_A_LSB = 8;
  localparam int FIELD_B_LSB = 16;
  localparam int FIELD_C_LSB = 24;

endpackage

// File: rtl/cpu_regs.sv
module cpu_regs #(
  parameter int W    = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RIW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [RIW-1:0] raddr_a,
  input  logic [RIW-1:0] raddr_b,
  output logic [W-1:0]   rdata_a,
  output logic [W-1:0]   rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_core_pkg::*;
#(
  parameter int W = 32
) (
  input  opcode_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_INV: res = ~x;
      OP_ADD: res = x + y;
      OP_SUB: res = x - y;
      OP_MUL: res = x * y;
      OP_DIV: res = (y == '0) ? '1 : x / y;
      OP_MOD: res = (y == '0) ? x : x % y;
      OP_SHR: res = x >> y;
      OP_SHL: res = x << y;
      OP_OR:  res = x | y;
      OP_XOR: res = x ^ y;
      OP_AND: res = x & y;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/cpu_irq_pick.sv
module cpu_irq_pick #(
  parameter int NIRQ = 4,
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0] req,
  output logic            valid,
  output logic [IW-1:0]   idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  logic [NIRQ-1:0] below;
  assign below = (NIRQ'(1) << idx) - NIRQ'(1);

  always_comb begin
    if (valid) begin
      AST_PICK_LOWEST: assert (req[idx] && ((req & below) == '0)); // R12
    end
  end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_core_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          NREG     = 8,
  parameter int          NIRQ     = 4,
  parameter logic [31:0] RESET_IP = 32'h0,
  parameter logic [31:0] RESET_SP = 32'h0,
  parameter logic [31:0] VEC_BASE = 32'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] irq_req,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  output logic            prf_stb,
  output logic [W-1:0]    prf_line,
  output logic            halted
);
  localparam int RIW  = $clog2(NREG);
  localparam int IW   = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [W-1:0] STEP = W'(4);

  state_e          state;
  opcode_e         op_q;
  logic [RIW-1:0]  fa, fb, fc;
  logic [W-1:0]    ip, sp;
  logic            ie, swi_pend;
  logic            iret_regs;
  logic [RIW-1:0]  iret_cnt;

  logic [W-1:0]    rd_a, rd_b, alu_y;
  logic            rf_we;
  logic [RIW-1:0]  rf_waddr;
  logic [W-1:0]    rf_wdata;
  logic [NIRQ-1:0] req_all;
  logic            pick_valid;
  logic [IW-1:0]   pick_idx;

  cpu_regs #(.W(W), .NREG(NREG)) u_regs (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(fa), .raddr_b(fb), .rdata_a(rd_a), .rdata_b(rd_b)
  );

  cpu_alu #(.W(W)) u_alu (.op(op_q), .x(rd_a), .y(rd_b), .res(alu_y));

  always_comb begin
    req_all    = irq_req;
    req_all[0] = irq_req[0] | swi_pend;
  end

  cpu_irq_pick #(.NIRQ(NIRQ)) u_pick (.req(req_all), .valid(pick_valid), .idx(pick_idx));

  // register-file write port
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = fa;
    rf_wdata = alu_y;
    if (state == ST_EXEC) begin
      case (op_q)
        OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_SHR, OP_SHL,
        OP_OR, OP_XOR, OP_AND: begin rf_we = 1'b1; rf_waddr = fc; end
        OP_INV: begin rf_we = 1'b1; rf_waddr = fb; end
        OP_MOV: begin rf_we = 1'b1; rf_waddr = fb; rf_wdata = rd_a; end
        OP_SSP: begin rf_we = 1'b1; rf_wdata = sp; end
        default: ;
      endcase
    end else if (state == ST_RDATA) begin
      case (op_q)
        OP_LDC, OP_LDM: begin rf_we = 1'b1; rf_waddr = fb; rf_wdata = mem_rdata; end
        OP_LDR: begin rf_we = 1'b1; rf_waddr = fb; rf_wdata = ip + mem_rdata; end
        OP_POP: begin rf_we = 1'b1; rf_wdata = mem_rdata; end
        OP_IRET: begin
          rf_we    = iret_regs;
          rf_waddr = iret_cnt;
          rf_wdata = mem_rdata;
        end
        default: ;
      endcase
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BOUND;
      op_q      <= OP_HALT;
      fa        <= '0;
      fb        <= '0;
      fc        <= '0;
      ip        <= W'(RESET_IP);
      sp        <= W'(RESET_SP);
      ie        <= 1'b0;
      swi_pend  <= 1'b0;
      iret_regs <= 1'b0;
      iret_cnt  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      prf_stb   <= 1'b0;
      prf_line  <= '0;
      halted    <= 1'b0;
    end else begin
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      prf_stb <= 1'b0;
      case (state)
        ST_BOUND: begin
          if (ie && pick_valid) begin
            mem_wr    <= 1'b1;
            mem_addr  <= sp;
            mem_wdata <= ip;
            sp        <= sp + STEP;
            ie        <= 1'b0;
            ip        <= W'(VEC_BASE) + (W'(pick_idx) << 2);
            if (pick_idx == '0) swi_pend <= 1'b0;
          end else begin
            mem_rd   <= 1'b1;
            mem_addr <= ip;
            state    <= ST_FWAIT;
          end
        end
        ST_FWAIT: state <= ST_DECODE;
        ST_DECODE: begin
          op_q  <= opcode_e'(mem_rdata[7:0]);
          fa    <= mem_rdata[FIELD_A_LSB +: RIW];
          fb    <= mem_rdata[FIELD_B_LSB +: RIW];
          fc    <= mem_rdata[FIELD_C_LSB +: RIW];
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_BOUND;
          ip    <= ip + STEP;
          case (op_q)
            OP_HALT: begin state <= ST_HALT; halted <= 1'b1; ip <= ip; end
            OP_JMP:  ip <= rd_a;
            OP_LDC, OP_LDR: begin
              mem_rd   <= 1'b1;
              mem_addr <= ip + STEP;
              ip       <= ip;
              state    <= ST_RWAIT;
            end
            OP_STM: begin mem_wr <= 1'b1; mem_addr <= rd_b; mem_wdata <= rd_a; end
            OP_LDM: begin
              mem_rd   <= 1'b1;
              mem_addr <= rd_a;
              ip       <= ip;
              state    <= ST_RWAIT;
            end
            OP_OUT:  begin prf_stb <= 1'b1; prf_line <= rd_a; end
            OP_JGT:  if ($signed(rd_a) > 0) ip <= rd_b;
            OP_IEN:  ie <= 1'b1;
            OP_IDIS: ie <= 1'b0;
            OP_LSP:  sp <= rd_a;
            OP_PSH: begin
              mem_wr    <= 1'b1;
              mem_addr  <= sp;
              mem_wdata <= rd_a;
              sp        <= sp + STEP;
            end
            OP_POP, OP_RET: begin ip <= ip; state <= ST_POPREQ; end
            OP_IRET: begin
              ip        <= ip;
              iret_regs <= 1'b1;
              iret_cnt  <= RIW'(NREG - 1);
              state     <= ST_POPREQ;
            end
            OP_SWI: swi_pend <= 1'b1;
            OP_CALL: begin
              mem_wr    <= 1'b1;
              mem_addr  <= sp;
              mem_wdata <= ip + STEP;
              sp        <= sp + STEP;
              ip        <= rd_a;
            end
            default: ;
          endcase
        end
        ST_POPREQ: begin
          sp       <= sp - STEP;
          mem_rd   <= 1'b1;
          mem_addr <= sp - STEP;
          state    <= ST_RWAIT;
        end
        ST_RWAIT: state <= ST_RDATA;
        ST_RDATA: begin
          state <= ST_BOUND;
          case (op_q)
            OP_LDC, OP_LDR: ip <= ip + STEP + STEP;
            OP_LDM, OP_POP: ip <= ip + STEP;
            OP_RET:         ip <= mem_rdata;
            OP_IRET: begin
              if (iret_regs) begin
                if (iret_cnt == '0) iret_regs <= 1'b0;
                else                iret_cnt  <= iret_cnt - 1'b1;
                state <= ST_POPREQ;
              end else begin
                ip <= mem_rdata;
                ie <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R14
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> (halted && !mem_rd && !mem_wr)); // R1
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst) prf_stb |=> !prf_stb); // R10
  AST_ENTRY_PUSH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BOUND && ie && pick_valid) |=> (!ie && mem_wr && mem_addr == $past(sp))); // R12
  AST_IRET_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA && op_q == OP_IRET && !iret_regs) |=> ie); // R13
  AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BOUND && !ie) |=> !mem_wr); // R11
endmodule

// File: tb/sim_cpu_core.sv
module sim_cpu_core;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 1024;

  localparam logic [7:0] O_NOP = 8'h01, O_JMP = 8'h02, O_LDC = 8'h03, O_STM = 8'h04,
    O_LDM = 8'h05, O_OUT = 8'h06, O_JGT = 8'h07, O_IEN = 8'h08, O_IDIS = 8'h09,
    O_LDR = 8'h0A, O_LSP = 8'h0B, O_PSH = 8'h0C, O_POP = 8'h0D, O_SWI = 8'h0E,
    O_CALL = 8'h0F, O_RET = 8'h10, O_IRET = 8'h11, O_SSP = 8'h12, O_MOV = 8'h13,
    O_INV = 8'h20, O_ADD = 8'h21;

  // {opcode, A, B, expected}
  localparam int NV = 16;
  localparam logic [103:0] VT [NV] = '{
    {8'h21, 32'd5,        32'd7,        32'd12},
    {8'h21, 32'hFFFFFFFF, 32'd1,        32'd0},
    {8'h22, 32'd3,        32'd5,        32'hFFFFFFFE},
    {8'h23, 32'h00010000, 32'h00010000, 32'd0},
    {8'h23, 32'd7,        32'd6,        32'd42},
    {8'h24, 32'd100,      32'd7,        32'd14},
    {8'h24, 32'h80000000, 32'd2,        32'h40000000},
    {8'h24, 32'd9,        32'd0,        32'hFFFFFFFF},
    {8'h25, 32'd100,      32'd7,        32'd2},
    {8'h25, 32'd9,        32'd0,        32'd9},
    {8'h26, 32'h80000000, 32'd4,        32'h08000000},
    {8'h27, 32'd1,        32'd31,       32'h80000000},
    {8'h28, 32'h000000F0, 32'h0000000F, 32'h000000FF},
    {8'h29, 32'h000000FF, 32'h0000000F, 32'h000000F0},
    {8'h2A, 32'h0000F0F0, 32'h0000FF00, 32'h0000F000},
    {8'h20, 32'h0F0F0F0F, 32'd0,        32'hF0F0F0F0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq = 4'b0;
  logic        mem_rd, mem_wr, prf_stb, halted;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, prf_line;

  logic [31:0] mem [MW];
  logic        ld_en = 1'b0, clr = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;

  int nchk = 0, nfail = 0;
  int stb_cnt, post_halt;
  logic [31:0] stb_line, vec_addr;
  logic vec_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_core u0 (
    .clk(clk), .rst(rst), .irq_req(irq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .prf_stb(prf_stb), .prf_line(prf_line), .halted(halted)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < MW; i++) mem[i] <= '0;
    end else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:2]];
  end

  always @(posedge clk) begin
    if (rst) begin
      stb_cnt = 0; post_halt = 0; stb_line = '0; vec_seen = 1'b0; vec_addr = '0;
    end else begin
      if (prf_stb) begin stb_cnt++; stb_line = prf_line; end
      if (halted && (mem_rd || mem_wr)) post_halt++;
      if (mem_rd && !vec_seen && mem_addr >= 32'h100 && mem_addr < 32'h200) begin
        vec_seen = 1'b1; vec_addr = mem_addr;
      end
    end
  end

  function automatic logic [31:0] enc(input logic [7:0] op, input int a, input int b, input int c);
    return {5'b0, c[2:0], 5'b0, b[2:0], 5'b0, a[2:0], op};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    ld_addr = a[11:2]; ld_data = d; ld_en = 1'b1;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  // load constant into register r at address a (two words)
  task automatic put_ldc(input logic [31:0] a, input int r, input logic [31:0] k);
    put(a, enc(O_LDC, 0, r, 0));
    put(a + 4, k);
  endtask

  task automatic prep();
    rst = 1'b1; irq = '0; clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
  endtask

  task automatic go(input string tag);
    int n = 0;
    rst = 1'b0;
    while (!halted && n < 4000) begin @(posedge clk); #1; n++; end
    chk({tag, " halts"}, {31'b0, halted}, 32'd1);
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL R1 watchdog: got running expected halted");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // ALU vector table: R3, R4
    for (int k = 0; k < NV; k++) begin
      logic [7:0] op;
      op = VT[k][103:96];
      prep();
      put_ldc(32'h00, 1, VT[k][95:64]);
      put_ldc(32'h08, 2, VT[k][63:32]);
      put(32'h10, (op == O_INV) ? enc(O_INV, 1, 3, 0) : enc(op, 1, 2, 3));
      put_ldc(32'h14, 4, 32'h400);
      put(32'h1C, enc(O_STM, 3, 4, 0));
      go("R3 alu");
      chk($sformatf("R3 R4 alu op %h", op), rdm(32'h400), VT[k][31:0]);
    end

    // reset state and halt timing: R1, R14
    prep();
    repeat (2) @(posedge clk);
    #1;
    chk("R14 reset mem_rd", {31'b0, mem_rd}, 32'd0);
    chk("R14 reset mem_wr", {31'b0, mem_wr}, 32'd0);
    chk("R10 reset strobe", {31'b0, prf_stb}, 32'd0);
    chk("R1 reset halted", {31'b0, halted}, 32'd0);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 not yet halted", {31'b0, halted}, 32'd0);
    @(posedge clk); #1;
    chk("R1 halted on fourth edge", {31'b0, halted}, 32'd1);
    repeat (20) @(posedge clk);
    #1;
    chk("R1 halted sticky", {31'b0, halted}, 32'd1);
    chk("R1 no access after halt", post_halt, 0);

    // LDC / MOV / LSP / SSP: R2, R4, R7
    prep();
    put_ldc(32'h00, 1, 32'h12345678);
    put(32'h08, enc(O_MOV, 1, 5, 0));
    put_ldc(32'h0C, 2, 32'h300);
    put(32'h14, enc(O_LSP, 2, 0, 0));
    put(32'h18, enc(O_SSP, 6, 0, 0));
    put_ldc(32'h1C, 4, 32'h400);
    put(32'h24, enc(O_STM, 5, 4, 0));
    put_ldc(32'h28, 3, 32'h404);
    put(32'h30, enc(O_STM, 6, 3, 0));
    go("R2 ldc");
    chk("R2 R4 ldc then mov", rdm(32'h400), 32'h12345678);
    chk("R4 R7 ssp after lsp", rdm(32'h404), 32'h300);

    // JGT signed: R6
    prep();
    put_ldc(32'h00, 1, 32'h80000000);
    put_ldc(32'h08, 2, 32'h40);
    put(32'h10, enc(O_JGT, 1, 2, 0));
    put_ldc(32'h14, 3, 32'd1);
    put_ldc(32'h1C, 1, 32'd2);
    put(32'h24, enc(O_JGT, 1, 2, 0));
    put_ldc(32'h28, 3, 32'hBAD);
    put_ldc(32'h40, 4, 32'h400);
    put(32'h48, enc(O_STM, 3, 4, 0));
    go("R6 jgt");
    chk("R6 jgt negative falls through, positive jumps", rdm(32'h400), 32'd1);

    // stack: R7
    prep();
    put_ldc(32'h00, 1, 32'h800);
    put(32'h08, enc(O_LSP, 1, 0, 0));
    put_ldc(32'h0C, 2, 32'hAAAA5555);
    put(32'h14, enc(O_PSH, 2, 0, 0));
    put_ldc(32'h18, 2, 32'h1111);
    put(32'h20, enc(O_PSH, 2, 0, 0));
    put(32'h24, enc(O_POP, 5, 0, 0));
    put(32'h28, enc(O_POP, 6, 0, 0));
    put(32'h2C, enc(O_SSP, 7, 0, 0));
    put_ldc(32'h30, 4, 32'h400);
    put(32'h38, enc(O_STM, 5, 4, 0));
    put_ldc(32'h3C, 4, 32'h404);
    put(32'h44, enc(O_STM, 6, 4, 0));
    put_ldc(32'h48, 4, 32'h408);
    put(32'h50, enc(O_STM, 7, 4, 0));
    go("R7 stack");
    chk("R7 first push at SP", rdm(32'h800), 32'hAAAA5555);
    chk("R7 second push above", rdm(32'h804), 32'h1111);
    chk("R7 pop last pushed", rdm(32'h400), 32'h1111);
    chk("R7 pop first pushed", rdm(32'h404), 32'hAAAA5555);
    chk("R7 sp restored", rdm(32'h408), 32'h800);

    // call / ret / jmp: R8, R6
    prep();
    put_ldc(32'h00, 1, 32'h800);
    put(32'h08, enc(O_LSP, 1, 0, 0));
    put_ldc(32'h0C, 2, 32'h60);
    put(32'h14, enc(O_CALL, 2, 0, 0));
    put_ldc(32'h18, 4, 32'h404);
    put(32'h20, enc(O_STM, 3, 4, 0));
    put_ldc(32'h24, 5, 32'h80);
    put(32'h2C, enc(O_JMP, 5, 0, 0));
    put_ldc(32'h60, 3, 32'h77);
    put(32'h68, enc(O_RET, 0, 0, 0));
    put_ldc(32'h80, 6, 32'h55);
    put_ldc(32'h88, 4, 32'h408);
    put(32'h90, enc(O_STM, 6, 4, 0));
    go("R8 call");
    chk("R8 call pushes ip+4", rdm(32'h800), 32'h18);
    chk("R8 ret resumes after call", rdm(32'h404), 32'h77);
    chk("R6 jmp reaches target", rdm(32'h408), 32'h55);

    // load relative: R9
    prep();
    put(32'h00, enc(O_NOP, 0, 0, 0));
    put(32'h04, enc(O_LDR, 0, 2, 0));
    put(32'h08, 32'hFFFFFFF8);
    put(32'h0C, enc(O_LDR, 0, 3, 0));
    put(32'h10, 32'h100);
    put_ldc(32'h14, 4, 32'h400);
    put(32'h1C, enc(O_STM, 2, 4, 0));
    put_ldc(32'h20, 4, 32'h404);
    put(32'h28, enc(O_STM, 3, 4, 0));
    go("R9 ldr");
    chk("R9 ldr negative offset", rdm(32'h400), 32'hFFFFFFFC);
    chk("R9 ldr positive offset, ip+8", rdm(32'h404), 32'h10C);

    // peripheral strobe: R10
    prep();
    put_ldc(32'h00, 1, 32'd5);
    put(32'h08, enc(O_OUT, 1, 0, 0));
    put_ldc(32'h0C, 1, 32'd9);
    put(32'h14, enc(O_OUT, 1, 0, 0));
    go("R10 out");
    chk("R10 strobe count", stb_cnt, 2);
    chk("R10 strobe line", stb_line, 32'd9);

    // memory load/store: R5
    prep();
    put(32'h500, 32'hCAFEF00D);
    put_ldc(32'h00, 1, 32'h500);
    put(32'h08, enc(O_LDM, 1, 2, 0));
    put_ldc(32'h0C, 3, 32'h504);
    put(32'h14, enc(O_STM, 2, 3, 0));
    go("R5 mem");
    chk("R5 load then store", rdm(32'h504), 32'hCAFEF00D);

    // software interrupt taken: R12
    prep();
    put_ldc(32'h00, 1, 32'h800);
    put(32'h08, enc(O_LSP, 1, 0, 0));
    put(32'h0C, enc(O_IEN, 0, 0, 0));
    put(32'h10, enc(O_SWI, 0, 0, 0));
    put_ldc(32'h100, 2, 32'hABCD);
    put_ldc(32'h108, 3, 32'h400);
    put(32'h110, enc(O_STM, 2, 3, 0));
    go("R12 swi");
    chk("R12 swi pushes next ip", rdm(32'h800), 32'h14);
    chk("R12 swi vector 0x100", vec_addr, 32'h100);
    chk("R12 handler ran", rdm(32'h400), 32'hABCD);

    // software interrupt masked: R11
    prep();
    put(32'h00, enc(O_NOP, 0, 0, 0));
    put(32'h04, enc(O_SWI, 0, 0, 0));
    put_ldc(32'h100, 2, 32'hABCD);
    put_ldc(32'h108, 3, 32'h400);
    put(32'h110, enc(O_STM, 2, 3, 0));
    go("R11 masked swi");
    chk("R11 masked swi no vector", {31'b0, vec_seen}, 32'd0);
    chk("R11 masked swi no handler", rdm(32'h400), 32'd0);

    // lowest line wins: R12
    prep();
    irq = 4'b1100;
    put_ldc(32'h00, 1, 32'h800);
    put(32'h08, enc(O_LSP, 1, 0, 0));
    put(32'h0C, enc(O_IEN, 0, 0, 0));
    put(32'h10, enc(O_NOP, 0, 0, 0));
    put(32'h10C, enc(O_NOP, 0, 0, 0));
    go("R12 priority");
    chk("R12 lowest line vector", vec_addr, 32'h108);
    chk("R12 external entry pushes ip", rdm(32'h800), 32'h10);

    // disable after enable: R11
    prep();
    put(32'h00, enc(O_IEN, 0, 0, 0));
    put(32'h04, enc(O_IDIS, 0, 0, 0));
    for (int a = 32'h08; a < 32'h64; a += 4) put(a, enc(O_NOP, 0, 0, 0));
    put_ldc(32'h64, 2, 32'h99);
    put_ldc(32'h6C, 3, 32'h400);
    put(32'h74, enc(O_STM, 2, 3, 0));
    rst = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    irq = 4'b0010;
    go("R11 idis");
    chk("R11 disabled request ignored", {31'b0, vec_seen}, 32'd0);
    chk("R11 program completed", rdm(32'h400), 32'h99);

    // interrupt return: R13
    prep();
    put_ldc(32'h00, 1, 32'h800);
    put(32'h08, enc(O_LSP, 1, 0, 0));
    put_ldc(32'h0C, 2, 32'd5);
    put(32'h14, enc(O_IEN, 0, 0, 0));
    put(32'h18, enc(O_SWI, 0, 0, 0));
    put(32'h1C, enc(O_SWI, 0, 0, 0));
    put_ldc(32'h20, 4, 32'h604);
    put(32'h28, enc(O_STM, 2, 4, 0));
    put(32'h2C, enc(O_SSP, 7, 0, 0));
    put_ldc(32'h30, 4, 32'h608);
    put(32'h38, enc(O_STM, 7, 4, 0));
    for (int r = 0; r < 8; r++) put(32'h100 + 4 * r, enc(O_PSH, r, 0, 0));
    put_ldc(32'h120, 2, 32'd1);
    put_ldc(32'h128, 3, 32'h600);
    put(32'h130, enc(O_LDM, 3, 4, 0));
    put(32'h134, enc(O_ADD, 4, 2, 4));
    put(32'h138, enc(O_STM, 4, 3, 0));
    put(32'h13C, enc(O_IRET, 0, 0, 0));
    go("R13 iret");
    chk("R13 handler entered twice (ie re-set)", rdm(32'h600), 32'd2);
    chk("R13 registers restored", rdm(32'h604), 32'd5);
    chk("R13 stack balanced", rdm(32'h608), 32'h800);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule